// File: doc/BRIEF.md
# IQ Magnitude Threshold Clutter Counter

This block receives pairs of balance-corrected in-phase and quadrature samples from two video channels. For every pair it accepts, it forms an approximate magnitude without a square root: the larger absolute value plus half of the smaller one. It compares that magnitude against four threshold levels that arrive on input ports. Each threshold has its own saturating tally of the samples whose magnitude lies above it. These tallies are the clutter counts, and a host reads them through a small address/data read port. A single clear strobe resets all of the tallies.

In parallel with the counting path, each accepted pair goes unchanged into a sixteen-entry buffer. The buffer drives a ready/valid output stream. When the buffer is full, the sample input is held off, and a pair that is not accepted is neither stored nor counted.

Top module: `iq_clutter_tally`

## Requirements
- R1: The magnitude of a pair is max(|I|,|Q|) + floor(min(|I|,|Q|)/2), taken as an unsigned 16-bit value. I and Q are signed 16-bit two's complement, and |-32768| is 32768.
- R2: Threshold k sits in bits [16k+15:16k] of `thr_levels`. Its counter goes up by one in the cycle after an accepted pair whose magnitude is strictly greater than the threshold. A magnitude equal to the threshold leaves the counter unchanged.
- R3: Each counter is 16 bits wide and stops at 65535. Further hits leave it at 65535.
- R4: When `cnt_clr` is high at a clock edge, every counter becomes 0. The exception is a counter that sees a hit from a pair accepted in that same cycle: that counter becomes 1.
- R5: `rd_data` shows the counter selected by `rd_addr` (0 to 3) combinationally.
- R6: Accepted pairs leave on `out_i`/`out_q` in the order they were accepted, with their values unchanged, starting in the cycle after acceptance. While `out_valid` is high and `out_ready` is low, `out_valid` and the output data stay constant.
- R7: `in_ready` is low exactly while 16 pairs are held. A pair offered while `in_ready` is low is neither stored nor counted.
- R8: After reset, all counters read 0, `out_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Sample pair offered |
| in_ready | output | 1 | Block can take a pair |
| in_i | input | 16 | Corrected in-phase sample, signed |
| in_q | input | 16 | Corrected quadrature sample, signed |
| thr_levels | input | 64 | Four 16-bit unsigned thresholds, threshold k in bits [16k+15:16k] |
| cnt_clr | input | 1 | Clear strobe for all counters |
| rd_addr | input | 2 | Counter select for reading |
| rd_data | output | 16 | Selected counter value |
| out_valid | output | 1 | Buffered pair available |
| out_ready | input | 1 | Consumer takes the pair |
| out_i | output | 16 | Buffered in-phase sample |
| out_q | output | 16 | Buffered quadrature sample |

## Verification
Counter saturation is the hardest state to reach from the ports, because it needs 65535 hits without a clear. The stimulus sets every threshold to zero, holds `out_ready` high so the buffer never stalls, and streams more than 65535 nonzero pairs back to back. The other corners are reached by directed steps: a clear in the same cycle as a hit, a magnitude exactly equal to a threshold, the value -32768, and a buffer filled past full while the output is blocked. Between these directed steps, seeded random traffic with random stalls and clears runs against a model of the queue and the counters.

// File: rtl/iqct_pkg.sv
`timescale 1ns/1ps
package iqct_pkg;
  localparam int SAMPLE_W = 16;

  function automatic logic [SAMPLE_W-1:0] abs_val(input logic signed [SAMPLE_W-1:0] v);
    return v[SAMPLE_W-1] ? SAMPLE_W'(-v) : SAMPLE_W'(v);
  endfunction

  function automatic logic [SAMPLE_W-1:0] approx_mag(input logic signed [SAMPLE_W-1:0] a,
                                                     input logic signed [SAMPLE_W-1:0] b);
    logic [SAMPLE_W-1:0] ua, ub, hi, lo;
    ua = abs_val(a);
    ub = abs_val(b);
    hi = (ua >= ub) ? ua : ub;
    lo = (ua >= ub) ? ub : ua;
    return hi + (lo >> 1);
  endfunction
endpackage

// File: rtl/iqct_mag.sv
`timescale 1ns/1ps
module iqct_mag
  import iqct_pkg::*;
(
  input  logic signed [SAMPLE_W-1:0] s_i,
  input  logic signed [SAMPLE_W-1:0] s_q,
  output logic        [SAMPLE_W-1:0] mag
);
  always_comb mag = approx_mag(s_i, s_q);
endmodule

// File: rtl/iqct_counter.sv
`timescale 1ns/1ps
module iqct_counter #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          hit,
  output logic [CW-1:0] cnt
);
  localparam logic [CW-1:0] CMAX = {CW{1'b1}};

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt <= '0;
    else if (clr)        cnt <= hit ? CW'(1) : '0;
    else if (hit && cnt != CMAX) cnt <= cnt + CW'(1);
  end

  AST_CLR_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt <= CW'(1))); // R4
  AST_SAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == CMAX && !clr) |=> (cnt == CMAX)); // R3
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !hit) |=> $stable(cnt)); // R2
endmodule

// File: rtl/iqct_fifo.sv
`timescale 1ns/1ps
module iqct_fifo #(
  parameter int DW    = 32,
  parameter int DEPTH = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_req,
  output logic          can_push,
  input  logic [DW-1:0] push_data,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_data
);
  localparam int PW = $clog2(DEPTH);

  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic [PW:0]   level;
  logic          push, pop;

  assign can_push  = (level != (PW+1)'(DEPTH));
  assign out_valid = (level != '0);
  assign push      = push_req && can_push;
  assign pop       = out_valid && out_ready;
  assign out_data  = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      if (push) wr_ptr <= (wr_ptr == PW'(DEPTH-1)) ? '0 : wr_ptr + PW'(1);
      if (pop)  rd_ptr <= (rd_ptr == PW'(DEPTH-1)) ? '0 : rd_ptr + PW'(1);
      level <= level + (push ? (PW+1)'(1) : '0) - (pop ? (PW+1)'(1) : '0);
    end
  end

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data))); // R6
  AST_FULL_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (level == (PW+1)'(DEPTH) && !pop) |=> !can_push); // R7
endmodule

// File: rtl/iq_clutter_tally.sv
`timescale 1ns/1ps
module iq_clutter_tally
  import iqct_pkg::*;
#(
  parameter int NTHR  = 4,
  parameter int CW    = 16,
  parameter int DEPTH = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       in_valid,
  output logic                       in_ready,
  input  logic [SAMPLE_W-1:0]        in_i,
  input  logic [SAMPLE_W-1:0]        in_q,
  input  logic [NTHR*SAMPLE_W-1:0]   thr_levels,
  input  logic                       cnt_clr,
  input  logic [$clog2(NTHR)-1:0]    rd_addr,
  output logic [CW-1:0]              rd_data,
  output logic                       out_valid,
  input  logic                       out_ready,
  output logic [SAMPLE_W-1:0]        out_i,
  output logic [SAMPLE_W-1:0]        out_q
);
  logic [SAMPLE_W-1:0]   mag;
  logic                  accept;
  logic [NTHR-1:0]       hit;
  logic [CW-1:0]         cnt [NTHR];
  logic [2*SAMPLE_W-1:0] out_pair;

  assign accept = in_valid && in_ready;

  iqct_mag u_mag (
    .s_i (in_i),
    .s_q (in_q),
    .mag (mag)
  );

  for (genvar k = 0; k < NTHR; k++) begin : g_thr
    assign hit[k] = accept && (mag > thr_levels[k*SAMPLE_W +: SAMPLE_W]);
    iqct_counter #(.CW(CW)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (cnt_clr),
      .hit   (hit[k]),
      .cnt   (cnt[k])
    );
  end

  assign rd_data = cnt[rd_addr];

  iqct_fifo #(.DW(2*SAMPLE_W), .DEPTH(DEPTH)) u_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .push_req  (in_valid),
    .can_push  (in_ready),
    .push_data ({in_i, in_q}),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_pair)
  );

  assign out_i = out_pair[2*SAMPLE_W-1:SAMPLE_W];
  assign out_q = out_pair[SAMPLE_W-1:0];

  AST_STALL_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |-> (hit == '0)); // R7
endmodule

// File: tb/iq_clutter_tally_tb.sv
`timescale 1ns/1ps
module iq_clutter_tally_tb_top;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        in_valid = 0, out_ready = 0, cnt_clr = 0;
  logic [15:0] in_i = 0, in_q = 0;
  logic [63:0] thr_levels = 0;
  logic [1:0]  rd_addr = 0;
  logic        in_ready, out_valid;
  logic [15:0] rd_data, out_i, out_q;

  int checks = 0, errors = 0;
  logic [31:0] q_mdl[$];
  int cnt_mdl[4];

  always #2.5 clk = ~clk;

  iq_clutter_tally dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_i(in_i), .in_q(in_q), .thr_levels(thr_levels), .cnt_clr(cnt_clr),
    .rd_addr(rd_addr), .rd_data(rd_data), .out_valid(out_valid),
    .out_ready(out_ready), .out_i(out_i), .out_q(out_q)
  );

  function automatic int ref_mag(input logic [15:0] a, input logic [15:0] b);
    int x, y;
    x = $signed(a); y = $signed(b);
    if (x < 0) x = -x;
    if (y < 0) y = -y;
    if (x < y) return y + x / 2;
    return x + y / 2;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input bit v, input logic [15:0] i, input logic [15:0] q,
                      input bit ordy, input bit clr);
    bit acc, pop;
    int m;
    @(negedge clk);
    in_valid = v; in_i = i; in_q = q; out_ready = ordy; cnt_clr = clr;
    #0.5;
    acc = v && (q_mdl.size() < 16);
    pop = ordy && (q_mdl.size() > 0);
    chk(in_ready == (q_mdl.size() < 16), "R7 in_ready", in_ready, q_mdl.size() < 16);
    chk(out_valid == (q_mdl.size() > 0), "R6 out_valid", out_valid, q_mdl.size() > 0);
    if (q_mdl.size() > 0)
      chk({out_i, out_q} == q_mdl[0], "R6 out data", {out_i, out_q}, q_mdl[0]);
    m = ref_mag(i, q);
    @(posedge clk);
    for (int k = 0; k < 4; k++) begin
      bit h;
      h = acc && (m > int'(thr_levels[16*k +: 16]));
      if (clr) cnt_mdl[k] = h ? 1 : 0;
      else if (h && cnt_mdl[k] < 65535) cnt_mdl[k]++;
    end
    if (pop) void'(q_mdl.pop_front());
    if (acc) q_mdl.push_back({i, q});
    #0.1;
    in_valid = 0; cnt_clr = 0; out_ready = 0;
  endtask

  task automatic check_counts(input string req);
    @(negedge clk);
    for (int k = 0; k < 4; k++) begin
      rd_addr = 2'(k);
      #0.3;
      chk(rd_data == 16'(cnt_mdl[k]), req, rd_data, cnt_mdl[k]);
    end
  endtask

  task automatic check_lit(input int e0, input int e1, input int e2, input int e3, input string req);
    int e[4];
    e = '{e0, e1, e2, e3};
    @(negedge clk);
    for (int k = 0; k < 4; k++) begin
      rd_addr = 2'(k);
      #0.3;
      chk(rd_data == 16'(e[k]), req, rd_data, e[k]);
    end
  endtask

  initial begin
    repeat (20000 * 10) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h1D2C));
    repeat (4) @(posedge clk);
    #0.1 rst_n = 1;
    // R8 reset state
    @(negedge clk);
    chk(in_ready == 1, "R8 in_ready", in_ready, 1);
    chk(out_valid == 0, "R8 out_valid", out_valid, 0);
    check_lit(0, 0, 0, 0, "R8 counters");

    // R1 R2: magnitude of -32768/100 is 32818; equality must not count
    thr_levels = {16'd0, 16'd32819, 16'd32817, 16'd32818};
    step(1, 16'h8000, 16'd100, 1, 0);
    check_lit(0, 1, 0, 1, "R1 R2 equal and above");
    // R1: 3 and -7 -> 7 + 1 = 8
    thr_levels = {16'd8, 16'd7, 16'd9, 16'd0};
    step(1, 16'd3, -16'sd7, 1, 0);
    check_lit(1, 1, 1, 1, "R1 small magnitude");
    check_counts("R5 read mux");

    // R4: clear coinciding with a hit
    thr_levels = {16'd60000, 16'd0, 16'd60000, 16'd0};
    step(1, 16'd50, 16'd50, 1, 1);
    check_lit(1, 0, 1, 0, "R4 clear with hit");
    step(0, 0, 0, 1, 1);
    check_lit(0, 0, 0, 0, "R4 plain clear");

    // R7: fill with output blocked, offer more than fits
    thr_levels = 64'd0;
    for (int n = 0; n < 20; n++) step(1, 16'(n + 1), 16'(n), 0, 0);
    check_lit(16, 16, 16, 16, "R7 stalled samples not counted");
    for (int n = 0; n < 20; n++) step(0, 0, 0, 1, 0);
    chk(out_valid == 0, "R6 drained", out_valid, 0);

    // random traffic
    for (int n = 0; n < 4000; n++) begin
      logic [15:0] ri, rq;
      if (n % 200 == 0)
        for (int k = 0; k < 4; k++) thr_levels[16*k +: 16] = 16'($urandom_range(0, 40000));
      case ($urandom_range(0, 9))
        0: ri = 16'h8000;
        1: ri = 16'h7FFF;
        default: ri = 16'($urandom);
      endcase
      rq = ($urandom_range(0, 9) == 0) ? 16'h0 : 16'($urandom);
      step($urandom_range(0, 3) != 0, ri, rq, $urandom_range(0, 2) != 0,
           $urandom_range(0, 49) == 0);
      if (n % 50 == 0) check_counts("R2 R4 random counts");
    end
    check_counts("R2 random counts end");

    // R3 saturation
    thr_levels = 64'd0;
    step(0, 0, 0, 1, 1);
    for (int n = 0; n < 65540; n++) step(1, 16'd5, 16'd5, 1, 0);
    check_lit(65535, 65535, 65535, 65535, "R3 saturation");
    check_counts("R3 model");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule